// File: doc/BRIEF.md
# Interrupt Master Enable and Halt Sequencer

This block owns the processor's global interrupt enable bit and its low-power halt state. Decode sends it single-cycle strobes: disable, enable, return-from-interrupt, halt and instruction-complete. It also sees the per-source enable mask and request flags. From these it decides whether an interrupt is taken at an instruction boundary, and which one. On a take it reports the handler entry address and a one-hot clear for the request flag. It can also tell the fetch unit to keep the program counter where it is for one fetch.

An enable strobe is armed first. The master enable rises only when the next instruction after the enable completes. Return-from-interrupt sets the master enable without that delay. A halt has three outcomes:
- Master enable set: the block sleeps until an enabled request appears, then wakes straight into service.
- Master enable clear, nothing pending: the block sleeps, then wakes without service.
- Master enable clear, something already pending: the block does not sleep. Instead it raises the increment-suppress pulse, so the byte after the halt is fetched twice.

Among simultaneous requests, bit 0 wins. The entry address is 0x40 plus 8 times the winning index.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After reset, ime_o, halted_o, svc_req_o and pc_hold_o are 0 and irq_ack_o is all zeros.
- R2: A dis_i strobe makes ime_o 0 from the next cycle. It also cancels an enable that is still armed, so later completions do not raise ime_o.
- R3: An ena_i strobe does not change ime_o in the cycles that follow it. ime_o becomes 1 in the cycle after the first later cycle that has instr_done_i high; idle cycles in between do not count.
- R4: A reti_i strobe (without dis_i and with no enabled request) makes ime_o 1 from the next cycle.
- R5: On a take, svc_req_o is high for exactly one cycle. In that cycle irq_ack_o is one-hot at the lowest index i with irq_en_i[i] & irq_flag_i[i], and svc_vec_o equals 0x40 + 8*i.
- R6: A take happens only when ime_o is 1, an enabled request exists, and either instr_done_i is high without dis_i or halt_i, or the block is halted. The take clears ime_o in the same cycle that svc_req_o rises.
- R7: A halt with ime_o at 1 sets halted_o, which stays 1 while no enabled request exists. The first enabled request clears halted_o and produces a take in the same cycle.
- R8: A halt with ime_o at 0 and no enabled request sets halted_o. The first enabled request clears halted_o with svc_req_o staying 0.
- R9: A halt with ime_o at 0 and an enabled request already present leaves halted_o at 0 and raises pc_hold_o for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dis_i | input | 1 | Disable-interrupts strobe |
| ena_i | input | 1 | Enable-interrupts strobe (delayed effect) |
| reti_i | input | 1 | Return-from-interrupt strobe |
| halt_i | input | 1 | Halt strobe |
| instr_done_i | input | 1 | An instruction completed this cycle |
| irq_en_i | input | 5 | Per-source enable mask |
| irq_flag_i | input | 5 | Per-source request flags |
| ime_o | output | 1 | Interrupt master enable |
| halted_o | output | 1 | Core is halted |
| svc_req_o | output | 1 | One-cycle interrupt service request |
| svc_vec_o | output | 8 | Handler entry address of the taken source |
| irq_ack_o | output | 5 | One-hot clear for the taken request flag |
| pc_hold_o | output | 1 | Suppress program-counter increment on the next fetch |

## Verification
The hardest situation to reach is the halt with the master enable clear and a request already waiting. It needs ime_o at 0, a fresh enabled request and a halt strobe all in the same cycle, and the only visible effect is a single pulse on pc_hold_o. The bench gets there by first taking an interrupt, which clears ime_o. It then lets a second halt sleep and wake without service, and finally raises mask and flag together with the halt strobe. The delayed enable is checked separately: idle cycles are placed between the enable and the next completion, which shows that only a completion, not elapsed time, releases the master enable.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;

    localparam int IRQ_LINES  = 5;
    localparam int VEC_W      = 8;
    localparam int VEC_BASE   = 'h40;
    localparam int VEC_STRIDE = 8;

    // control bits held by the sequencer
    typedef struct packed {
        logic ime;
        logic ei_armed;
        logic halted;
        logic svc;
        logic pc_hold;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{default: 1'b0};

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx
);

    logic [N:0] lower;

    assign lower[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign lower[g+1] = lower[g] | req[g];
            assign grant[g]   = req[g] & ~lower[g];
        end
    endgenerate

    assign any = lower[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
    parameter int IW     = 3,
    parameter int VW     = 8,
    parameter int BASE   = 'h40,
    parameter int STRIDE = 8
) (
    input  logic [IW-1:0] idx,
    output logic [VW-1:0] vec
);

    localparam logic [VW-1:0] BASE_V   = VW'(BASE);
    localparam logic [VW-1:0] STRIDE_V = VW'(STRIDE);

    assign vec = BASE_V + STRIDE_V * VW'(idx);

endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
    import irq_halt_pkg::*;
#(
    parameter int NUM_IRQ = IRQ_LINES,
    parameter int VW      = VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dis_i,
    input  logic               ena_i,
    input  logic               reti_i,
    input  logic               halt_i,
    input  logic               instr_done_i,
    input  logic [NUM_IRQ-1:0] irq_en_i,
    input  logic [NUM_IRQ-1:0] irq_flag_i,
    output logic               ime_o,
    output logic               halted_o,
    output logic               svc_req_o,
    output logic [VW-1:0]      svc_vec_o,
    output logic [NUM_IRQ-1:0] irq_ack_o,
    output logic               pc_hold_o
);

    localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    ctl_state_t         st_d, st_q;
    logic [VW-1:0]      vec_d, vec_q;
    logic [NUM_IRQ-1:0] ack_d, ack_q;

    logic [NUM_IRQ-1:0] pend;
    logic               pend_any;
    logic [NUM_IRQ-1:0] grant;
    logic [IW-1:0]      win_idx;
    logic [VW-1:0]      win_vec;
    logic               take;

    assign pend = irq_en_i & irq_flag_i;

    irq_prio_pick #(.N(NUM_IRQ), .IW(IW)) u_pick (
        .req   (pend),
        .any   (pend_any),
        .grant (grant),
        .idx   (win_idx)
    );

    irq_vec_gen #(.IW(IW), .VW(VW), .BASE(VEC_BASE), .STRIDE(VEC_STRIDE)) u_vec (
        .idx (win_idx),
        .vec (win_vec)
    );

    always_comb begin
        st_d         = st_q;
        st_d.svc     = 1'b0;
        st_d.pc_hold = 1'b0;
        vec_d        = vec_q;
        ack_d        = '0;
        take         = 1'b0;

        if (st_q.halted) begin
            // sleeping: any enabled request wakes, service only if enabled
            if (pend_any) begin
                st_d.halted = 1'b0;
                take        = st_q.ime;
            end
        end else begin
            if (dis_i) begin
                st_d.ime      = 1'b0;
                st_d.ei_armed = 1'b0;
            end else begin
                if (ena_i)
                    st_d.ei_armed = 1'b1;
                else if (instr_done_i)
                    st_d.ei_armed = 1'b0;

                if (reti_i)
                    st_d.ime = 1'b1;
                else if (st_q.ei_armed && instr_done_i && !ena_i)
                    st_d.ime = 1'b1;

                take = st_q.ime && pend_any && instr_done_i && !halt_i;
            end

            if (halt_i) begin
                if (st_q.ime || !pend_any)
                    st_d.halted = 1'b1;
                else
                    st_d.pc_hold = 1'b1;
            end
        end

        if (take) begin
            st_d.ime = 1'b0;
            st_d.svc = 1'b1;
            vec_d    = win_vec;
            ack_d    = grant;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CTL_RESET;
            vec_q <= '0;
            ack_q <= '0;
        end else begin
            st_q  <= st_d;
            vec_q <= vec_d;
            ack_q <= ack_d;
        end
    end

    assign ime_o     = st_q.ime;
    assign halted_o  = st_q.halted;
    assign svc_req_o = st_q.svc;
    assign svc_vec_o = vec_q;
    assign irq_ack_o = ack_q;
    assign pc_hold_o = st_q.pc_hold;

endmodule

// File: rtl/irq_halt_ctrl_chk.sv
module irq_halt_ctrl_chk #(
    parameter int NUM_IRQ = 5,
    parameter int VW      = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dis_i,
    input logic               ena_i,
    input logic               reti_i,
    input logic               halt_i,
    input logic               instr_done_i,
    input logic [NUM_IRQ-1:0] irq_en_i,
    input logic [NUM_IRQ-1:0] irq_flag_i,
    input logic               ime_o,
    input logic               halted_o,
    input logic               svc_req_o,
    input logic [VW-1:0]      svc_vec_o,
    input logic [NUM_IRQ-1:0] irq_ack_o,
    input logic               pc_hold_o
);

    logic any_req;
    assign any_req = (irq_en_i & irq_flag_i) != '0;

    assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack_o));

    assert_svc_has_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_o |-> $countones(irq_ack_o) == 1);

    assert_svc_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_o && !halted_o |=> !svc_req_o || $past(instr_done_i) || !ime_o);

    assert_take_clears_ime_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_o |-> !ime_o);

    assert_dis_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i && !halted_o |=> !ime_o);

    assert_ena_no_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ena_i && !reti_i && !ime_o && !halted_o |=> !ime_o);

    assert_reti_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i && !dis_i && !halted_o && !any_req |=> ime_o);

    assert_halt_wake_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o && ime_o && any_req |=> svc_req_o && !halted_o);

    assert_halt_wake_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o && !ime_o && any_req |=> !svc_req_o && !halted_o);

    assert_pc_hold_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold_o |=> !pc_hold_o);

endmodule

bind irq_halt_ctrl irq_halt_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .VW(VW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dis_i        (dis_i),
    .ena_i        (ena_i),
    .reti_i       (reti_i),
    .halt_i       (halt_i),
    .instr_done_i (instr_done_i),
    .irq_en_i     (irq_en_i),
    .irq_flag_i   (irq_flag_i),
    .ime_o        (ime_o),
    .halted_o     (halted_o),
    .svc_req_o    (svc_req_o),
    .svc_vec_o    (svc_vec_o),
    .irq_ack_o    (irq_ack_o),
    .pc_hold_o    (pc_hold_o)
);

// File: tb/irq_halt_ctrl_bench.sv
`timescale 1ns/1ps
module irq_halt_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dis_i = 0, ena_i = 0, reti_i = 0, halt_i = 0, instr_done_i = 0;
    logic [4:0] irq_en_i = '0, irq_flag_i = '0;
    logic       ime_o, halted_o, svc_req_o, pc_hold_o;
    logic [7:0] svc_vec_o;
    logic [4:0] irq_ack_o;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 0;
    string tag = "R1";

    // reference model state
    int m_ime = 0, m_arm = 0, m_halt = 0, m_svc = 0, m_hold = 0, m_vec = 0, m_ack = 0;

    always #4 clk = ~clk;

    irq_halt_ctrl u_irq_halt_ctrl (
        .clk(clk), .rst_n(rst_n), .dis_i(dis_i), .ena_i(ena_i), .reti_i(reti_i),
        .halt_i(halt_i), .instr_done_i(instr_done_i), .irq_en_i(irq_en_i),
        .irq_flag_i(irq_flag_i), .ime_o(ime_o), .halted_o(halted_o),
        .svc_req_o(svc_req_o), .svc_vec_o(svc_vec_o), .irq_ack_o(irq_ack_o),
        .pc_hold_o(pc_hold_o)
    );

    task automatic compare_all();
        bit bad;
        bad = (ime_o != m_ime[0]) || (halted_o != m_halt[0]) || (svc_req_o != m_svc[0]) ||
              (pc_hold_o != m_hold[0]) || (svc_vec_o != m_vec[7:0]) || (irq_ack_o != m_ack[4:0]);
        n_vec++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: got ime=%0d halt=%0d svc=%0d hold=%0d vec=%h ack=%b exp ime=%0d halt=%0d svc=%0d hold=%0d vec=%h ack=%b",
                     tag, ime_o, halted_o, svc_req_o, pc_hold_o, svc_vec_o, irq_ack_o,
                     m_ime, m_halt, m_svc, m_hold, m_vec[7:0], m_ack[4:0]);
        end
    endtask

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: drive inputs, advance model, compare after the edge
    task automatic step(input bit di, input bit ei, input bit rt, input bit hl,
                        input bit dn, input int en, input int fl);
        int req, win, n_ime, n_arm, n_halt, n_svc, n_hold, n_vec_v, n_ack;
        dis_i = di; ena_i = ei; reti_i = rt; halt_i = hl; instr_done_i = dn;
        irq_en_i = en[4:0]; irq_flag_i = fl[4:0];
        req = en & fl & 31;
        win = -1;
        for (int k = 4; k >= 0; k--) if (req[k]) win = k;
        n_ime = m_ime; n_arm = m_arm; n_halt = m_halt; n_svc = 0; n_hold = 0;
        n_vec_v = m_vec; n_ack = 0;
        if (m_halt == 1) begin
            if (win >= 0) begin
                n_halt = 0;
                if (m_ime == 1) begin
                    n_ime = 0; n_svc = 1; n_vec_v = 64 + 8 * win; n_ack = 1 << win;
                end
            end
        end else begin
            if (di) begin
                n_ime = 0; n_arm = 0;
            end else begin
                if (ei) n_arm = 1;
                else if (dn) n_arm = 0;
                if (rt) n_ime = 1;
                else if (m_arm == 1 && dn) n_ime = 1;
                if (m_ime == 1 && win >= 0 && dn && !hl) begin
                    n_ime = 0; n_svc = 1; n_vec_v = 64 + 8 * win; n_ack = 1 << win;
                end
            end
            if (hl) begin
                if (m_ime == 1 || win < 0) n_halt = 1;
                else n_hold = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        m_ime = n_ime; m_arm = n_arm; m_halt = n_halt; m_svc = n_svc;
        m_hold = n_hold; m_vec = n_vec_v; m_ack = n_ack;
        compare_all();
    endtask

    task automatic idle(input int en, input int fl);
        step(0, 0, 0, 0, 0, en, fl);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        chk(ime_o == 0 && halted_o == 0 && svc_req_o == 0 && pc_hold_o == 0 && irq_ack_o == 0,
            "reset state", {ime_o, halted_o, svc_req_o, pc_hold_o, irq_ack_o}, 0);
        idle(0, 0);

        // R3: delayed enable, completion-driven
        tag = "R3";
        step(0, 1, 0, 0, 1, 0, 0);
        chk(ime_o == 0, "ime after enable", ime_o, 0);
        idle(0, 0); idle(0, 0);
        chk(ime_o == 0, "ime across idle cycles", ime_o, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        chk(ime_o == 1, "ime after next completion", ime_o, 1);

        // R2: disable immediate, and cancels an armed enable
        tag = "R2";
        step(1, 0, 0, 0, 1, 0, 0);
        chk(ime_o == 0, "ime after disable", ime_o, 0);
        step(0, 1, 0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        chk(ime_o == 0, "armed enable cancelled", ime_o, 0);

        // R4: reti immediate
        tag = "R4";
        step(0, 0, 1, 0, 1, 0, 0);
        chk(ime_o == 1, "ime after reti", ime_o, 1);

        // R6: no take without a completion
        tag = "R6";
        idle(5'b10110, 5'b10100);
        chk(svc_req_o == 0, "no take on idle", svc_req_o, 0);
        // R5: priority and vector (bit 2 lowest pending)
        tag = "R5";
        step(0, 0, 0, 0, 1, 5'b10110, 5'b10100);
        chk(svc_req_o == 1 && svc_vec_o == 8'h50 && irq_ack_o == 5'b00100,
            "take bit2", {svc_req_o, svc_vec_o, irq_ack_o}, {1'b1, 8'h50, 5'b00100});
        chk(ime_o == 0, "R6 take clears ime", ime_o, 0);
        idle(0, 0);
        chk(svc_req_o == 0, "svc one cycle", svc_req_o, 0);

        // R7: halt with ime set
        tag = "R7";
        step(0, 0, 1, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        idle(0, 0); idle(5'b11111, 0); idle(0, 5'b11111);
        chk(halted_o == 1, "still halted", halted_o, 1);
        idle(5'b11111, 5'b10000);
        chk(halted_o == 0 && svc_req_o == 1 && svc_vec_o == 8'h60 && irq_ack_o == 5'b10000,
            "wake with take bit4", {halted_o, svc_req_o, svc_vec_o}, {1'b0, 1'b1, 8'h60});
        idle(0, 0);

        // R8: halt with ime clear, nothing pending
        tag = "R8";
        step(0, 0, 0, 1, 0, 5'b00001, 0);
        chk(halted_o == 1, "halted", halted_o, 1);
        idle(0, 0);
        idle(5'b00010, 5'b00010);
        chk(halted_o == 0 && svc_req_o == 0, "quiet wake", {halted_o, svc_req_o}, 0);

        // R9: halt with ime clear and request pending
        tag = "R9";
        step(0, 0, 0, 1, 0, 5'b00001, 5'b00001);
        chk(halted_o == 0 && pc_hold_o == 1, "hold pulse", {halted_o, pc_hold_o}, 1);
        idle(5'b00001, 5'b00001);
        chk(pc_hold_o == 0, "hold single cycle", pc_hold_o, 0);

        // R5: lowest index wins when all requested
        tag = "R5";
        step(0, 0, 1, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 5'b11111, 5'b11111);
        chk(svc_vec_o == 8'h40 && irq_ack_o == 5'b00001, "bit0 wins", svc_vec_o, 8'h40);
        idle(0, 0);
        report();
    end

endmodule